// File: doc/BRIEF.md
# Palette RAM Access Port

This block is the host-side programming port of a color lookup table. A host reaches it through four byte-wide register offsets on a plain strobe bus. Through these offsets it selects a table entry and streams 24-bit colors into two tables, one byte at a time. The main table has 256 entries and the overlay table has 4. The same port reads colors back, and it reaches a small bank of control bytes indirectly through the shared entry index.

Color bytes pass through a sub-index that steps red, then green, then blue. When the third byte arrives, the whole color is written into the selected entry and the entry index moves on. When a written color differs from the value it replaces, a one-cycle change pulse goes out. A separate combinational lookup port lets a pixel pipeline fetch any entry of either table. The control bytes are exported as a flat vector.

Top module: `pal_port_top`

## Requirements
- R1: A write to offset 0 loads the entry index with the written byte and returns the sub-index to red, which discards any partly written color. A read of offset 0 returns the entry index.
- R2: Writes to offset 1 supply red, green and blue in that order. The blue write stores the color into main entry `index` as {red[23:16], green[15:8], blue[7:0]} and increments the index.
- R3: The main-table index wraps from 255 to 0 after a commit.
- R4: Reads of offset 1 return the red, green and blue bytes of the current main entry in that order. After blue, the index moves to the next entry.
- R5: Offset 2 reaches control byte k = index − 4 only while the index is 4 to 7. A write stores into that byte and a read returns it. For any other index a read returns 0 and a write changes nothing. Control byte k appears on `ctrl_regs[8k+7:8k]`.
- R6: Offset 3 uses the same red/green/blue sequence on overlay entry `index` while the index is 0 to 3, and the index wraps from 3 to 0. For an index of 4 or more, writes are ignored (index and tables keep their values) and reads return 0.
- R7: `pal_changed` is high for exactly the one cycle after a commit edge whose new color differs from the stored one. A commit of an identical color gives no pulse.
- R8: A synchronous active-high reset clears the index, the sub-index, the control bytes, both tables and the read data.
- R9: `lut_addr` 0–255 returns main entries and 256–259 returns overlay entries 0–3, combinationally. Any other address returns 0.
- R10: `bus_rdata` is registered. It takes the read value at the edge that samples `bus_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| lut_addr | input | 9 | Lookup address (main, then overlay) |
| lut_color | output | 24 | Looked-up color, red in 23:16 |
| ctrl_regs | output | 32 | Control bytes, byte k at 8k+7:8k |
| pal_changed | output | 1 | One-cycle pulse after a changing commit |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle, and that each strobe marks a single access. The sequencing properties on the index and sub-index depend on this. The stimulus drives each access as a one-cycle strobe set at the falling edge, and it never combines a read with a write. Reads are queued as expected bytes and compared after the edge that registers them. Pulse counts and lookup colors are checked at the ports.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] r;
        logic [BYTE_W-1:0] g;
        logic [BYTE_W-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        PORT_INDEX = 2'd0,
        PORT_MAIN  = 2'd1,
        PORT_CTRL  = 2'd2,
        PORT_OVL   = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        COMP_R = 2'd0,
        COMP_G = 2'd1,
        COMP_B = 2'd2
    } comp_e;

    function automatic logic [BYTE_W-1:0] pick_comp(rgb_t c, comp_e s);
        case (s)
            COMP_R:  return c.r;
            COMP_G:  return c.g;
            default: return c.b;
        endcase
    endfunction

    function automatic comp_e next_comp(comp_e s);
        case (s)
            COMP_R:  return COMP_G;
            COMP_G:  return COMP_B;
            default: return COMP_R;
        endcase
    endfunction

endpackage

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  rgb_t          wcolor,
    input  logic [AW-1:0] raddr,
    output rgb_t          rcolor,
    input  logic [AW-1:0] laddr,
    output rgb_t          lcolor,
    output logic          differs
);

    rgb_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wcolor;
        end
    end

    assign rcolor  = mem[raddr];
    assign lcolor  = mem[laddr];
    assign differs = we && (mem[waddr] != wcolor);

endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl
    import pal_pkg::*;
#(
    parameter int NUM  = 4,
    parameter int BASE = 4,
    parameter int IW   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IW-1:0]     idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic              hit,
    output logic [BYTE_W-1:0] rdata,
    output logic [NUM*BYTE_W-1:0] regs_flat
);

    logic [BYTE_W-1:0] regs [NUM];

    assign hit = (int'(idx) >= BASE) && (int'(idx) < BASE + NUM);

    for (genvar k = 0; k < NUM; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) regs[k] <= '0;
            else if (we && hit && int'(idx) == BASE + k) regs[k] <= wdata;
        end
        assign regs_flat[k*BYTE_W +: BYTE_W] = regs[k];
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM; k++)
            if (int'(idx) == BASE + k) rdata = regs[k];
    end

    AST_CTRL_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (we && !hit) |=> $stable(regs_flat)); // R5

endmodule

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IW         = 8,
    parameter int MAIN_DEPTH = 256,
    parameter int OVL_DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  rgb_t              main_rcolor,
    input  rgb_t              ovl_rcolor,
    input  logic              ctrl_hit,
    input  logic [BYTE_W-1:0] ctrl_rdata,
    output logic [IW-1:0]     idx,
    output logic              main_we,
    output logic              ovl_we,
    output logic              ctrl_we,
    output rgb_t              commit_color,
    output logic [BYTE_W-1:0] rdata
);

    localparam logic [IW-1:0] MAIN_LAST = IW'(MAIN_DEPTH - 1);
    localparam logic [IW-1:0] OVL_LAST  = IW'(OVL_DEPTH - 1);
    localparam logic [IW-1:0] ONE       = IW'(1);

    port_e             port;
    comp_e             sub;
    logic [BYTE_W-1:0] hold_r, hold_g;
    logic              ovl_ok, wr_idx, wr_main, wr_ovl, rd_main, rd_ovl;
    logic              step_main, step_ovl, last;
    logic [IW-1:0]     idx_n;
    comp_e             sub_n;
    logic [BYTE_W-1:0] rd_val;

    assign port    = port_e'(bus_addr);
    assign ovl_ok  = int'(idx) < OVL_DEPTH;
    assign wr_idx  = bus_wr && port == PORT_INDEX;
    assign wr_main = bus_wr && port == PORT_MAIN;
    assign wr_ovl  = bus_wr && port == PORT_OVL && ovl_ok;
    assign rd_main = bus_rd && !bus_wr && port == PORT_MAIN;
    assign rd_ovl  = bus_rd && !bus_wr && port == PORT_OVL && ovl_ok;
    assign ctrl_we = bus_wr && port == PORT_CTRL;

    assign step_main = wr_main || rd_main;
    assign step_ovl  = wr_ovl || rd_ovl;
    assign last      = (sub == COMP_B);

    assign main_we      = wr_main && last;
    assign ovl_we       = wr_ovl && last;
    assign commit_color = '{r: hold_r, g: hold_g, b: bus_wdata};

    always_comb begin
        idx_n = idx;
        sub_n = sub;
        if (wr_idx) begin
            idx_n = bus_wdata[IW-1:0];
            sub_n = COMP_R;
        end else if (step_main) begin
            sub_n = next_comp(sub);
            if (last) idx_n = (idx == MAIN_LAST) ? '0 : idx + ONE;
        end else if (step_ovl) begin
            sub_n = next_comp(sub);
            if (last) idx_n = (idx == OVL_LAST) ? '0 : idx + ONE;
        end
    end

    always_comb begin
        case (port)
            PORT_INDEX: rd_val = BYTE_W'(idx);
            PORT_MAIN:  rd_val = pick_comp(main_rcolor, sub);
            PORT_CTRL:  rd_val = ctrl_hit ? ctrl_rdata : '0;
            default:    rd_val = ovl_ok ? pick_comp(ovl_rcolor, sub) : '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx    <= '0;
            sub    <= COMP_R;
            hold_r <= '0;
            hold_g <= '0;
            rdata  <= '0;
        end else begin
            idx <= idx_n;
            sub <= sub_n;
            if ((wr_main || wr_ovl) && sub == COMP_R) hold_r <= bus_wdata;
            if ((wr_main || wr_ovl) && sub == COMP_G) hold_g <= bus_wdata;
            if (bus_rd && !bus_wr) rdata <= rd_val;
        end
    end

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_idx |=> (idx == $past(bus_wdata[IW-1:0]) && sub == COMP_R)); // R1

    AST_MAIN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step_main && last && idx == MAIN_LAST) |=> idx == '0); // R3

    AST_OVL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step_ovl && last && idx == OVL_LAST) |=> idx == '0); // R6

    AST_OVL_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && port == PORT_OVL && !ovl_ok) |=> $stable(idx)); // R6

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(rdata)); // R10

endmodule

// File: rtl/pal_port_top.sv
module pal_port_top
    import pal_pkg::*;
#(
    parameter int MAIN_DEPTH = 256,
    parameter int OVL_DEPTH  = 4,
    parameter int CTRL_NUM   = 4,
    parameter int CTRL_BASE  = 4,
    localparam int IW   = BYTE_W,
    localparam int MAW  = $clog2(MAIN_DEPTH),
    localparam int OAW  = (OVL_DEPTH > 1) ? $clog2(OVL_DEPTH) : 1,
    localparam int LAW  = $clog2(MAIN_DEPTH + OVL_DEPTH),
    localparam int CW   = CTRL_NUM * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [LAW-1:0]    lut_addr,
    output logic [23:0]       lut_color,
    output logic [CW-1:0]     ctrl_regs,
    output logic              pal_changed
);

    logic [IW-1:0]     idx;
    logic              main_we, ovl_we, ctrl_we, ctrl_hit;
    logic              main_diff, ovl_diff, chg_q;
    logic [BYTE_W-1:0] ctrl_rdata;
    rgb_t              commit_color, main_rcolor, ovl_rcolor, main_lcolor, ovl_lcolor;

    pal_seq #(.IW(IW), .MAIN_DEPTH(MAIN_DEPTH), .OVL_DEPTH(OVL_DEPTH)) u_seq (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .main_rcolor(main_rcolor), .ovl_rcolor(ovl_rcolor),
        .ctrl_hit(ctrl_hit), .ctrl_rdata(ctrl_rdata),
        .idx(idx), .main_we(main_we), .ovl_we(ovl_we), .ctrl_we(ctrl_we),
        .commit_color(commit_color), .rdata(bus_rdata)
    );

    pal_store #(.DEPTH(MAIN_DEPTH)) u_main (
        .clk(clk), .rst(rst), .we(main_we), .waddr(idx[MAW-1:0]), .wcolor(commit_color),
        .raddr(idx[MAW-1:0]), .rcolor(main_rcolor),
        .laddr(lut_addr[MAW-1:0]), .lcolor(main_lcolor), .differs(main_diff)
    );

    pal_store #(.DEPTH(OVL_DEPTH)) u_ovl (
        .clk(clk), .rst(rst), .we(ovl_we), .waddr(idx[OAW-1:0]), .wcolor(commit_color),
        .raddr(idx[OAW-1:0]), .rcolor(ovl_rcolor),
        .laddr(lut_addr[OAW-1:0]), .lcolor(ovl_lcolor), .differs(ovl_diff)
    );

    pal_ctrl #(.NUM(CTRL_NUM), .BASE(CTRL_BASE), .IW(IW)) u_ctrl (
        .clk(clk), .rst(rst), .we(ctrl_we), .idx(idx), .wdata(bus_wdata),
        .hit(ctrl_hit), .rdata(ctrl_rdata), .regs_flat(ctrl_regs)
    );

    always_comb begin
        if (int'(lut_addr) < MAIN_DEPTH)                  lut_color = main_lcolor;
        else if (int'(lut_addr) < MAIN_DEPTH + OVL_DEPTH) lut_color = ovl_lcolor;
        else                                               lut_color = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) chg_q <= 1'b0;
        else     chg_q <= main_diff || ovl_diff;
    end
    assign pal_changed = chg_q;

    AST_CHG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pal_changed |=> !pal_changed); // R7

    AST_CHG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        pal_changed |-> $past(main_we || ovl_we)); // R7

endmodule

// File: tb/pal_port_top_tb_top.sv
module pal_port_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [8:0]  lut_addr = '0;
    logic [23:0] lut_color;
    logic [31:0] ctrl_regs;
    logic        pal_changed;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses   = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    pal_port_top dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lut_addr(lut_addr),
        .lut_color(lut_color), .ctrl_regs(ctrl_regs), .pal_changed(pal_changed)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic look(logic [8:0] a, logic [23:0] exp, string tag);
        @(negedge clk);
        lut_addr = a;
        #1 chk(tag, 32'(lut_color), 32'(exp));
    endtask

    task automatic rgb(logic [1:0] a, logic [23:0] c);
        wr(a, c[23:16]); wr(a, c[15:8]); wr(a, c[7:0]);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        if (bus_rd && !rst) begin
            #1;
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R10: unexpected read, actual %h expected none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
            end
        end
    end

    always @(posedge clk) if (!rst && pal_changed) pulses++;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        int p0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R8 reset state
        rd(0, 8'h00, "R8 index after reset");
        look(9'd0, 24'h0, "R8 main entry after reset");
        look(9'd257, 24'h0, "R8 overlay entry after reset");
        chk("R8 ctrl after reset", ctrl_regs, 32'h0);

        // R2 commit + R7 pulse
        p0 = pulses;
        wr(0, 8'd10);
        rgb(1, 24'h112233);
        look(9'd10, 24'h112233, "R2 packed commit");
        rd(0, 8'd11, "R2 index advance");
        chk("R7 pulse on change", pulses - p0, 1);

        // R7 no pulse on identical color
        p0 = pulses;
        wr(0, 8'd10);
        rgb(1, 24'h112233);
        repeat (2) @(negedge clk);
        chk("R7 no pulse on same color", pulses - p0, 0);

        // R3 wrap
        wr(0, 8'd255);
        rgb(1, 24'hAABBCC);
        rd(0, 8'd0, "R3 index wrap");
        look(9'd255, 24'hAABBCC, "R3 last entry");

        // R4 readback
        wr(0, 8'd10);
        rd(1, 8'h11, "R4 read red");
        rd(1, 8'h22, "R4 read green");
        rd(1, 8'h33, "R4 read blue");
        rd(0, 8'd11, "R4 index after read");

        // R10 hold across writes
        wr(0, 8'd40);
        @(negedge clk);
        chk("R10 rdata held", 32'(bus_rdata), 32'd11);

        // R1 sub-index reset
        wr(0, 8'd20);
        wr(1, 8'h01); wr(1, 8'h02);
        wr(0, 8'd20);
        rgb(1, 24'h050607);
        look(9'd20, 24'h050607, "R1 partial color discarded");

        // R5 control bytes
        wr(0, 8'd6);
        wr(2, 8'h5A);
        @(negedge clk);
        chk("R5 ctrl byte 2", ctrl_regs, 32'h005A0000);
        rd(2, 8'h5A, "R5 ctrl read");
        wr(0, 8'd9);
        wr(2, 8'hFF);
        @(negedge clk);
        chk("R5 write outside range ignored", ctrl_regs, 32'h005A0000);
        rd(2, 8'h00, "R5 read outside range");

        // R6 overlay
        p0 = pulses;
        wr(0, 8'd3);
        rgb(3, 24'hDEADBE);
        look(9'd259, 24'hDEADBE, "R6 overlay commit");
        rd(0, 8'd0, "R6 overlay index wrap");
        chk("R7 pulse on overlay change", pulses - p0, 1);
        wr(0, 8'd3);
        rd(3, 8'hDE, "R6 overlay read red");
        wr(0, 8'd5);
        rgb(3, 24'h123456);
        rd(0, 8'd5, "R6 index kept when out of range");
        look(9'd256, 24'h0, "R6 overlay 0 untouched");
        look(9'd259, 24'hDEADBE, "R6 overlay 3 untouched");
        rd(3, 8'h00, "R6 read out of range");

        // R9 lookup decode
        look(9'd300, 24'h0, "R9 unmapped lookup");
        look(9'd10, 24'h112233, "R9 main lookup");

        // R8 reset clears state again
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        look(9'd10, 24'h0, "R8 main cleared");
        look(9'd259, 24'h0, "R8 overlay cleared");
        chk("R8 ctrl cleared", ctrl_regs, 32'h0);
        chk("R8 rdata cleared", 32'(bus_rdata), 32'h0);

        repeat (3) @(negedge clk);
        finished = 1;
        summary();
    end

endmodule